// File: doc/BRIEF.md
# Two-Word Funnel Shifter with Half Select

This block shifts a 64-bit value, formed by placing an upper 32-bit word above a lower 32-bit word, left or right by 0 to 63 positions. Right shifts can be logical or arithmetic. Only one 32-bit half of the shifted value leaves the block, picked by a half-select input. A datapath uses it for single-word shifts, for sign-extended shifts and for two-word (long) shifts that produce one result half per cycle.

Two input words arrive from the surrounding datapath. Small source selectors build the upper and lower shifter operands from zero, either input word, the sign of word B, or a held copy of word B. The held copy lives in a register that loads word B on every clock edge unless the stall input is high. On the first cycle of a long shift the register captures the word that the second cycle still needs: the low word for a left shift, the high word for a right shift. The shift itself is purely combinational.

Top module: `dword_funnel_shifter`

## Requirements
- R1: With `dir_i`=0 the 64-bit value {upper, lower} is shifted left by `count_i` and vacated low bits are filled with zeros, whatever `arith_i` says.
- R2: With `dir_i`=1 and `arith_i`=0 the value is shifted right and vacated high bits are filled with zeros.
- R3: With `dir_i`=1 and `arith_i`=1 the value is shifted right and vacated high bits take bit 63 of the unshifted value.
- R4: `half_i`=1 puts bits 63..32 of the shifted value on `result_o`; `half_i`=0 puts bits 31..0 there.
- R5: A count of zero passes the selected half of {upper, lower} to `result_o` unchanged.
- R6: `up_src_i` picks the upper operand: 0 zero, 1 `a_word_i`, 2 `b_word_i`, 3 thirty-two copies of `b_word_i[31]`, 4 the held word; codes 5 to 7 give zero.
- R7: `lo_src_i` picks the lower operand: 0 zero, 1 `a_word_i`, 2 `b_word_i`, 3 the held word.
- R8: At a rising clock edge with `stall_i`=0 the held word takes `b_word_i`; with `stall_i`=1 it keeps its value.
- R9: A rising clock edge with `rst`=1 clears the held word to zero.
- R10: A long shift finishes in two cycles: the first cycle yields one half from the live words and loads the needed word, and the second cycle, stalled, yields the other half from the held word. The pair of results equals one 64-bit shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the held word |
| stall_i | input | 1 | Freezes the held word when high |
| a_word_i | input | 32 | First operand word |
| b_word_i | input | 32 | Second operand word, source of the held word |
| up_src_i | input | 3 | Upper operand source code |
| lo_src_i | input | 2 | Lower operand source code |
| count_i | input | 6 | Shift distance, 0 to 63 |
| dir_i | input | 1 | 0 shift left, 1 shift right |
| arith_i | input | 1 | 1 selects sign fill on right shifts |
| half_i | input | 1 | 1 upper result half, 0 lower result half |
| result_o | output | 32 | Selected 32-bit half of the shifted value |

## Verification
The bench builds the block with its default word width of 32, so the count is six bits and every distance from 0 to 63 on the 64-bit value is reachable. At that width a full sweep of count, direction, fill mode and half select over several operand patterns stays within a few thousand cycles. Each source code and the load, hold and reset of the held word are all exercised. Long shifts in both directions are checked against a single 64-bit reference shift.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } shift_dir_e;

    typedef enum logic [2:0] {
        UP_ZERO  = 3'd0,
        UP_A     = 3'd1,
        UP_B     = 3'd2,
        UP_BSIGN = 3'd3,
        UP_HELD  = 3'd4
    } up_src_e;

    typedef enum logic [1:0] {
        LO_ZERO = 2'd0,
        LO_A    = 2'd1,
        LO_B    = 2'd2,
        LO_HELD = 2'd3
    } lo_src_e;

    typedef struct packed {
        shift_dir_e dir;
        logic       arith;
        logic       upper_half;
    } shift_ctl_t;

    // Fill bit entering the vacated positions of a stage.
    function automatic logic fill_bit(shift_ctl_t c, logic msb);
        return (c.dir == SH_RIGHT) && c.arith && msb;
    endfunction

endpackage

// File: rtl/operand_hold.sv
module operand_hold #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (!stall)
            q <= d;
    end
endmodule

// File: rtl/operand_select.sv
module operand_select
    import funnel_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [WORD_W-1:0] held_word,
    input  up_src_e           up_src,
    input  lo_src_e           lo_src,
    output logic [WORD_W-1:0] up_word,
    output logic [WORD_W-1:0] lo_word
);
    always_comb begin
        case (up_src)
            UP_A:     up_word = a_word;
            UP_B:     up_word = b_word;
            UP_BSIGN: up_word = {WORD_W{b_word[WORD_W-1]}};
            UP_HELD:  up_word = held_word;
            default:  up_word = '0;
        endcase
    end

    always_comb begin
        case (lo_src)
            LO_A:    lo_word = a_word;
            LO_B:    lo_word = b_word;
            LO_HELD: lo_word = held_word;
            default: lo_word = '0;
        endcase
    end
endmodule

// File: rtl/funnel_core.sv
module funnel_core
    import funnel_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int DW    = 2 * WORD_W,
    localparam int CNT_W = $clog2(DW)
) (
    input  logic [WORD_W-1:0] up_word,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [CNT_W-1:0]  count,
    input  shift_ctl_t        ctl,
    output logic [WORD_W-1:0] result
);
    logic [DW-1:0] stage [0:CNT_W];
    logic          fill;

    assign stage[0] = {up_word, lo_word};
    assign fill     = fill_bit(ctl, up_word[WORD_W-1]);

    // One stage per count bit; stage k moves by 2**k positions.
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [DW-1:0] moved;
        assign moved = (ctl.dir == SH_RIGHT)
                     ? {{S{fill}}, stage[k][DW-1:S]}
                     : {stage[k][DW-1-S:0], {S{1'b0}}};
        assign stage[k+1] = count[k] ? moved : stage[k];
    end

    assign result = ctl.upper_half ? stage[CNT_W][DW-1:WORD_W]
                                   : stage[CNT_W][WORD_W-1:0];
endmodule

// File: rtl/dword_funnel_shifter.sv
module dword_funnel_shifter
    import funnel_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic [WORD_W-1:0] a_word_i,
    input  logic [WORD_W-1:0] b_word_i,
    input  logic [2:0]        up_src_i,
    input  logic [1:0]        lo_src_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              dir_i,
    input  logic              arith_i,
    input  logic              half_i,
    output logic [WORD_W-1:0] result_o
);
    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] up_w;
    logic [WORD_W-1:0] lo_w;
    shift_ctl_t        ctl;

    assign ctl.dir        = shift_dir_e'(dir_i);
    assign ctl.arith      = arith_i;
    assign ctl.upper_half = half_i;

    operand_hold #(.WORD_W(WORD_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .stall (stall_i),
        .d     (b_word_i),
        .q     (held_q)
    );

    operand_select #(.WORD_W(WORD_W)) u_sel (
        .a_word    (a_word_i),
        .b_word    (b_word_i),
        .held_word (held_q),
        .up_src    (up_src_e'(up_src_i)),
        .lo_src    (lo_src_e'(lo_src_i)),
        .up_word   (up_w),
        .lo_word   (lo_w)
    );

    funnel_core #(.WORD_W(WORD_W)) u_core (
        .up_word (up_w),
        .lo_word (lo_w),
        .count   (count_i),
        .ctl     (ctl),
        .result  (result_o)
    );
endmodule

// File: rtl/funnel_checker.sv
module funnel_checker #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(2 * WORD_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              stall_i,
    input logic [WORD_W-1:0] b_word_i,
    input logic [WORD_W-1:0] held_q,
    input logic [WORD_W-1:0] up_w,
    input logic [WORD_W-1:0] lo_w,
    input logic [CNT_W-1:0]  count_i,
    input logic              dir_i,
    input logic              arith_i,
    input logic              half_i,
    input logic [WORD_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(WORD_W);

    p_hold_load_r8: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> held_q == $past(b_word_i));

    p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(held_q));

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (count_i == '0)
                p_pass_zero_r5: assert (result_o == (half_i ? up_w : lo_w))
                    else $error("zero count altered the selected half");
            if (!dir_i && count_i >= HALF_CNT && !half_i)
                p_left_zero_fill_r1: assert (result_o == '0)
                    else $error("left shift filled with ones");
            if (dir_i && !arith_i && count_i >= HALF_CNT && half_i)
                p_right_logic_fill_r2: assert (result_o == '0)
                    else $error("logical right shift did not fill zeros");
            if (dir_i && arith_i && count_i >= HALF_CNT && half_i)
                p_right_arith_fill_r3: assert (result_o == {WORD_W{up_w[WORD_W-1]}})
                    else $error("arithmetic right shift lost the sign");
        end
    end
endmodule

bind dword_funnel_shifter funnel_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall_i  (stall_i),
    .b_word_i (b_word_i),
    .held_q   (held_q),
    .up_w     (up_w),
    .lo_w     (lo_w),
    .count_i  (count_i),
    .dir_i    (dir_i),
    .arith_i  (arith_i),
    .half_i   (half_i),
    .result_o (result_o)
);

// File: tb/dword_funnel_shifter_test.sv
module dword_funnel_shifter_test;
    localparam int W  = 32;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall_i = 1'b0;
    logic [W-1:0]  a_word_i = '0;
    logic [W-1:0]  b_word_i = '0;
    logic [2:0]    up_src_i = '0;
    logic [1:0]    lo_src_i = '0;
    logic [CW-1:0] count_i = '0;
    logic          dir_i = 1'b0;
    logic          arith_i = 1'b0;
    logic          half_i = 1'b0;
    logic [W-1:0]  result_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_held = '0;

    dword_funnel_shifter #(.WORD_W(W)) uut (
        .clk(clk), .rst(rst), .stall_i(stall_i),
        .a_word_i(a_word_i), .b_word_i(b_word_i),
        .up_src_i(up_src_i), .lo_src_i(lo_src_i),
        .count_i(count_i), .dir_i(dir_i), .arith_i(arith_i),
        .half_i(half_i), .result_o(result_o)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] ref_shift(logic [2*W-1:0] v, int c, bit d, bit ar, bit h);
        logic [2*W-1:0] r;
        if (!d)      r = v << c;
        else if (ar) r = $unsigned($signed(v) >>> c);
        else         r = v >> c;
        return h ? r[2*W-1:W] : r[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_up(logic [W-1:0] a, logic [W-1:0] b, int s);
        case (s)
            1: return a;
            2: return b;
            3: return {W{b[W-1]}};
            4: return m_held;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_lo(logic [W-1:0] a, logic [W-1:0] b, int s);
        case (s)
            1: return a;
            2: return b;
            3: return m_held;
            default: return '0;
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] exp);
        checks++;
        if (result_o !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, result_o, exp);
        end
    endtask

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, int up, int lo,
                         int cnt, bit d, bit ar, bit h, bit st);
        a_word_i = a; b_word_i = b;
        up_src_i = 3'(up); lo_src_i = 2'(lo);
        count_i = CW'(cnt); dir_i = d; arith_i = ar; half_i = h;
        stall_i = st;
        #1;
    endtask

    // Advance one clock; the bench's own model of the held word follows.
    task automatic tick();
        @(posedge clk);
        if (rst)           m_held = '0;
        else if (!stall_i) m_held = b_word_i;
        @(negedge clk);
    endtask

    task automatic check_model(string tag);
        check(tag, ref_shift({ref_up(a_word_i, b_word_i, int'(up_src_i)),
                              ref_lo(a_word_i, b_word_i, int'(lo_src_i))},
                             int'(count_i), dir_i, arith_i, half_i));
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] pa [4];
        logic [W-1:0] pb [4];
        logic [W-1:0] hi_w, lo_wd;
        string tag;
        pa[0] = 32'h8000_0001; pb[0] = 32'h0000_0001;
        pa[1] = 32'h7FFF_FFFF; pb[1] = 32'hFFFF_FFFF;
        pa[2] = 32'hDEAD_BEEF; pb[2] = 32'h0123_4567;
        pa[3] = 32'h0F0F_3C3C; pb[3] = 32'hA5A5_5A5A;

        repeat (2) @(posedge clk);
        m_held = '0;
        @(negedge clk);
        rst = 1'b0;

        // R9: held word after reset reads back as zero
        drive('1, '1, 4, 3, 0, 0, 0, 1, 1);
        check("R9 held after reset upper", '0);
        drive('1, '1, 4, 3, 0, 0, 0, 0, 1);
        check("R9 held after reset lower", '0);

        // R1 R2 R3 R4 R5: exhaustive sweep over distance and controls
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 64; c++)
                for (int m = 0; m < 8; m++) begin
                    drive(pa[p], pb[p], 1, 2, c, m[2], m[1], m[0], 1);
                    if (c == 0)       tag = "R5";
                    else if (!m[2])   tag = "R1";
                    else if (!m[1])   tag = "R2";
                    else              tag = "R3";
                    check_model($sformatf("%s/R4 cnt=%0d dir=%0d ar=%0d half=%0d",
                                          tag, c, m[2], m[1], m[0]));
                end

        // R6 R7: every source code, with a known held word
        drive(32'h1111_2222, 32'h5A5A_0F0F, 0, 0, 0, 0, 0, 0, 0);
        tick();
        for (int u = 0; u < 8; u++)
            for (int l = 0; l < 4; l++)
                for (int h = 0; h < 2; h++) begin
                    drive(32'h1111_2222, 32'h9ABC_DEF0, u, l, 0, 0, 0, h[0], 1);
                    check_model($sformatf("R6/R7 up=%0d lo=%0d half=%0d", u, l, h));
                end

        // R6: sign-extended word shifted right arithmetically
        drive(0, 32'h8000_00F0, 3, 2, 4, 1, 1, 0, 1);
        check("R6 sign extend lower", 32'hF800_000F);
        drive(0, 32'h8000_00F0, 3, 2, 4, 1, 1, 1, 1);
        check("R6 sign extend upper", 32'hFFFF_FFFF);

        // R8: load when not stalled, keep when stalled
        drive(0, 32'hCAFE_0001, 4, 0, 0, 0, 0, 1, 0);
        tick();
        drive(0, 32'hBAD0_0002, 4, 0, 0, 0, 0, 1, 1);
        check("R8 loaded word", 32'hCAFE_0001);
        tick();
        check("R8 stall keeps word", 32'hCAFE_0001);
        drive(0, 32'hBAD0_0002, 4, 0, 0, 0, 0, 1, 0);
        tick();
        drive(0, 32'h0, 4, 0, 0, 0, 0, 1, 1);
        check("R8 reload after stall", 32'hBAD0_0002);

        // R10: long left shift, low word held for the second cycle
        hi_w = 32'hC0DE_1234; lo_wd = 32'h9876_5432;
        drive(hi_w, lo_wd, 1, 2, 12, 0, 0, 1, 0);
        check("R10 long left upper", ref_shift({hi_w, lo_wd}, 12, 0, 0, 1));
        tick();
        drive('1, '1, 0, 3, 12, 0, 0, 0, 1);
        check("R10 long left lower", ref_shift({hi_w, lo_wd}, 12, 0, 0, 0));
        tick();

        // R10: long arithmetic right shift, high word held
        hi_w = 32'h8765_4321; lo_wd = 32'h0FED_CBA9;
        drive(lo_wd, hi_w, 2, 1, 40, 1, 1, 0, 0);
        check("R10 long arith right lower", ref_shift({hi_w, lo_wd}, 40, 1, 1, 0));
        tick();
        drive('0, '0, 4, 0, 40, 1, 1, 1, 1);
        check("R10 long arith right upper", ref_shift({hi_w, lo_wd}, 40, 1, 1, 1));
        tick();

        // R10: long logical right shift, high word held
        drive(lo_wd, hi_w, 2, 1, 8, 1, 0, 0, 0);
        check("R10 long logic right lower", ref_shift({hi_w, lo_wd}, 8, 1, 0, 0));
        tick();
        drive('1, '1, 4, 0, 8, 1, 0, 1, 1);
        check("R10 long logic right upper", ref_shift({hi_w, lo_wd}, 8, 1, 0, 1));
        tick();

        // R9: reset in mid-run clears a loaded word, even when stalled
        drive(0, 32'h7777_7777, 4, 0, 0, 0, 0, 1, 0);
        tick();
        rst = 1'b1;
        drive(0, 32'h7777_7777, 4, 0, 0, 0, 0, 1, 1);
        tick();
        rst = 1'b0;
        drive(0, 32'h7777_7777, 4, 0, 0, 0, 0, 1, 1);
        check("R9 reset clears held word", '0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule